// File: doc/BRIEF.md
# Timer Pin Controller with Edge Interrupt

This block owns the single I/O pin of a general-purpose timer channel and its one interrupt line. A 32-bit mode register chooses what the pin does. The pin can be released, used as a capture input, driven by the waveform from the timer's counting datapath (compare or PWM functions), or used as a plain GPIO. Any driven value can be made open-drain, so that a logic one releases the pin instead of pulling it high.

On the input side, the pin passes through a flop synchroniser. A selectable edge detector on the synchronised level sets a sticky flag in a 32-bit status register. That register also returns the pin level. Software clears flags by writing ones to them. The interrupt output is the flag summary gated by an enable bit in the mode register. When capture edges are armed, the pin is an input only, so GPIO drive requests leave it released.

Both registers sit behind a synchronous write port and a combinational read mux. The counting datapath supplies its waveform and its other event flags through dedicated inputs.

Top module: `tpin_ctrl`

## Requirements
- R1: After reset the mode register and all flags are zero, the pin is released (`pin_oe`=0, `pin_out`=0) and `irq` is low.
- R2: Mode bits [2:0] select the function: 0 off, 1 capture, 2 compare, 3 PWM, 4 GPIO. In GPIO with bits [5:4]=10 the pin is driven low, with 11 it is driven high, and with 00 or 01 it is released.
- R3: With mode bit 9 set, a logic 1 releases the pin (`pin_oe`=0) and a logic 0 drives it low. With bit 9 clear, both levels are driven.
- R4: In functions 2 and 3 the driven value follows `cnt_wave` in the same cycle. In functions 0 and 1, and in the unused codes 5 to 7, the pin is released.
- R5: In GPIO, when mode bits [17:16] are nonzero (capture armed), output-drive requests in bits [5:4] have no effect and the pin stays released.
- R6: Status bit 8 shows `pin_in` after two clock edges of synchronisation.
- R7: Mode bits [17:16] choose the edge: 00 none, 01 rising, 10 falling, 11 either. A qualifying edge on the synchronised level sets status bit 0 on the third rising clock edge after `pin_in` changes.
- R8: Writing the status register clears each flag whose data bit is 1 and leaves the others alone. A flag set in the same cycle as its clear stays set.
- R9: `irq` is high exactly when mode bit 8 is set and any status flag [3:0] is set.
- R10: Reading address 0 returns the last mode value written. Reading address 1 returns the flags in [3:0], the pin level in bit 8 and zero in every other bit, whatever was written there.
- R11: A pulse on `evt_set[i]` sets status flag i+1 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | Write target: 0 mode, 1 status (write-one-to-clear) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read select: 0 mode, 1 status |
| rd_data | output | 32 | Read data, combinational |
| evt_set | input | 3 | Event pulses from the counting datapath for flags 3..1 |
| cnt_wave | input | 1 | Waveform from the counting datapath for compare/PWM |
| pin_in | input | 1 | Level seen at the pad |
| pin_oe | output | 1 | Pad drive enable |
| pin_out | output | 1 | Pad drive value (0 while released) |
| irq | output | 1 | Interrupt request |

## Verification
A stale synchroniser or previous-level flop shows up as a flag that sets one cycle early or late, or on the wrong polarity. The bench catches this three edges after a pin change, because it compares the status word every cycle. A corrupted flag or mode bit appears on `irq` and on `rd_data` in the same cycle it is registered. Drive-decode errors appear combinationally on `pin_oe`/`pin_out`, including the case where an armed capture must suppress a GPIO drive. Write-one-to-clear faults show up as a flag that survives a clear or vanishes without one, and the bench sees them one edge after the write.

// File: rtl/tpin_pkg.sv
package tpin_pkg;

   localparam int REG_W = 32;

   // pin function codes (mode bits [2:0])
   typedef enum logic [2:0] {
      PF_OFF  = 3'd0,
      PF_CAPT = 3'd1,
      PF_CMP  = 3'd2,
      PF_PWM  = 3'd3,
      PF_GPIO = 3'd4
   } pin_fn_e;

   // capture edge choice (mode bits [17:16])
   typedef enum logic [1:0] {
      EDG_NONE = 2'd0,
      EDG_RISE = 2'd1,
      EDG_FALL = 2'd2,
      EDG_ANY  = 2'd3
   } edge_sel_e;

   localparam int FN_LO      = 0;
   localparam int GPIO_VAL   = 4;
   localparam int GPIO_DRV   = 5;
   localparam int IRQ_EN_BIT = 8;
   localparam int OD_BIT     = 9;
   localparam int EDGE_LO    = 16;
   localparam int LVL_BIT    = 8;

endpackage

// File: rtl/tpin_sync.sv
module tpin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tpin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tpin_edge.sv
module tpin_edge
   import tpin_pkg::*;
#(
   parameter int FLAG_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lvl,
   input  edge_sel_e         sel,
   input  logic [FLAG_W-2:0] evt,
   input  logic [FLAG_W-1:0] clr,
   output logic              hit,
   output logic [FLAG_W-1:0] flags
);
   if (FLAG_W < 2) begin : g_bad_flag_w
      $error("tpin_edge: FLAG_W must be at least 2");
   end

   logic lvl_prev;
   logic rise, fall;

   assign rise = lvl & ~lvl_prev;
   assign fall = ~lvl & lvl_prev;

   always_comb begin
      unique case (sel)
         EDG_RISE: hit = rise;
         EDG_FALL: hit = fall;
         EDG_ANY:  hit = rise | fall;
         default:  hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_prev <= 1'b0;
         flags    <= '0;
      end else begin
         lvl_prev <= lvl;
         // a new event wins over a clear in the same cycle
         flags    <= (flags & ~clr) | {evt, hit};
      end
   end
endmodule

// File: rtl/tpin_drive.sv
module tpin_drive
   import tpin_pkg::*;
(
   input  pin_fn_e   fn,
   input  logic      gpio_drv,
   input  logic      gpio_val,
   input  logic      capt_armed,
   input  logic      open_drain,
   input  logic      wave,
   output logic      oe,
   output logic      out
);
   logic want, val;

   always_comb begin
      want = 1'b0;
      val  = 1'b0;
      unique case (fn)
         PF_CMP, PF_PWM: begin
            want = 1'b1;
            val  = wave;
         end
         PF_GPIO: begin
            want = gpio_drv & ~capt_armed;
            val  = gpio_val;
         end
         default: begin
            want = 1'b0;
            val  = 1'b0;
         end
      endcase
   end

   assign oe  = want & ~(open_drain & val);
   assign out = oe & val;
endmodule

// File: rtl/tpin_ctrl.sv
module tpin_ctrl
   import tpin_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FLAG_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              rd_addr,
   output logic [REG_W-1:0]  rd_data,
   input  logic [FLAG_W-2:0] evt_set,
   input  logic              cnt_wave,
   input  logic              pin_in,
   output logic              pin_oe,
   output logic              pin_out,
   output logic              irq
);
   if (FLAG_W > LVL_BIT) begin : g_bad_flags
      $error("tpin_ctrl: flags would overlap the level bit");
   end

   localparam logic ADDR_MODE = 1'b0;
   localparam logic ADDR_STAT = 1'b1;

   logic [REG_W-1:0]  mode_q;
   logic              lvl_s;
   logic              edge_hit;
   logic [FLAG_W-1:0] flags;
   logic [FLAG_W-1:0] clr_mask;
   logic [REG_W-1:0]  status_w;
   edge_sel_e         edge_sel;
   pin_fn_e           fn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mode_q <= '0;
      else if (wr_en && wr_addr == ADDR_MODE) mode_q <= wr_data;
   end

   assign clr_mask = (wr_en && wr_addr == ADDR_STAT) ? wr_data[FLAG_W-1:0] : '0;
   assign edge_sel = edge_sel_e'(mode_q[EDGE_LO+1:EDGE_LO]);
   assign fn       = pin_fn_e'(mode_q[FN_LO+2:FN_LO]);

   tpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (lvl_s)
   );

   tpin_edge #(.FLAG_W(FLAG_W)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl_s),
      .sel   (edge_sel),
      .evt   (evt_set),
      .clr   (clr_mask),
      .hit   (edge_hit),
      .flags (flags)
   );

   tpin_drive u_drive (
      .fn         (fn),
      .gpio_drv   (mode_q[GPIO_DRV]),
      .gpio_val   (mode_q[GPIO_VAL]),
      .capt_armed (edge_sel != EDG_NONE),
      .open_drain (mode_q[OD_BIT]),
      .wave       (cnt_wave),
      .oe         (pin_oe),
      .out        (pin_out)
   );

   always_comb begin
      status_w                 = '0;
      status_w[FLAG_W-1:0]     = flags;
      status_w[LVL_BIT]        = lvl_s;
   end

   assign rd_data = (rd_addr == ADDR_STAT) ? status_w : mode_q;
   assign irq     = mode_q[IRQ_EN_BIT] & (|flags);
endmodule

// File: rtl/tpin_ctrl_chk.sv
module tpin_ctrl_chk #(
   parameter int FLAG_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_addr,
   input logic [31:0]       wr_data,
   input logic [31:0]       mode_q,
   input logic [FLAG_W-1:0] flags,
   input logic              edge_hit,
   input logic              pin_oe,
   input logic              pin_out,
   input logic              irq
);
   p_od_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[9] && pin_oe) |-> !pin_out);

   p_quiet_fn_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2:0] == 3'd0 || mode_q[2:0] == 3'd1) |-> !pin_oe);

   p_input_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2:0] == 3'd4 && mode_q[17:16] != 2'b00) |-> !pin_oe);

   p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr && wr_data[0] && !edge_hit) |=> !flags[0]);

   p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[0] && !(wr_en && wr_addr && wr_data[0])) |=> flags[0]);

   p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q[8] |-> !irq);

   p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0) |-> !irq);
endmodule

bind tpin_ctrl tpin_ctrl_chk #(.FLAG_W(FLAG_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .mode_q   (mode_q),
   .flags    (flags),
   .edge_hit (edge_hit),
   .pin_oe   (pin_oe),
   .pin_out  (pin_out),
   .irq      (irq)
);

// File: tb/tb_tpin_ctrl.sv
`timescale 1ns/100ps
module tb_tpin_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_addr = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_addr = 1'b0;
   logic [31:0] rd_data;
   logic [2:0]  evt_set = '0;
   logic        cnt_wave = 1'b0;
   logic        pin_in = 1'b0;
   logic        pin_oe, pin_out, irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string tag = "R1";

   // reference state
   logic [31:0] m_mode;
   logic [3:0]  m_flags;
   bit          hist[$];   // pin samples, newest at the end

   always #2.5 clk = ~clk;   // 200 MHz

   tpin_ctrl dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .evt_set(evt_set), .cnt_wave(cnt_wave), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
   );

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_mode = '0;
      m_flags = '0;
      hist.delete();
      repeat (3) hist.push_back(1'b0);
   endtask

   task automatic model_edge();
      bit cur, old, hit;
      logic [3:0] clr;
      if (!rst_n) begin
         model_reset();
         return;
      end
      cur = hist[1];
      old = hist[0];
      case (m_mode[17:16])
         2'b01:   hit = cur && !old;
         2'b10:   hit = !cur && old;
         2'b11:   hit = cur != old;
         default: hit = 1'b0;
      endcase
      clr = (wr_en && wr_addr) ? wr_data[3:0] : 4'h0;
      m_flags = (m_flags & ~clr) | {evt_set, hit};
      if (wr_en && !wr_addr) m_mode = wr_data;
      hist.push_back(pin_in);
      void'(hist.pop_front());
   endtask

   task automatic compare();
      bit drv, val, eoe, eout;
      logic [31:0] stat;
      drv = 0; val = 0;
      case (m_mode[2:0])
         3'd2, 3'd3: begin drv = 1; val = cnt_wave; end
         3'd4: begin drv = m_mode[5] && (m_mode[17:16] == 2'b00); val = m_mode[4]; end
         default: drv = 0;
      endcase
      eoe  = drv && !(m_mode[9] && val);
      eout = eoe && val;
      stat = '0;
      stat[3:0] = m_flags;
      stat[8] = hist[1];
      chk("pin_oe", {31'd0, pin_oe}, {31'd0, eoe});
      chk("pin_out", {31'd0, pin_out}, {31'd0, eout});
      chk("irq", {31'd0, irq}, {31'd0, m_mode[8] && (m_flags != 0)});
      chk(rd_addr ? "rd_status" : "rd_mode", rd_data, rd_addr ? stat : m_mode);
   endtask

   task automatic step(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         model_edge();
         #1;
         if (!done) compare();
      end
   endtask

   task automatic wr(logic a, logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pin_set(bit v, int wait_n);
      pin_in = v;
      step(wait_n);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      // R1: reset state
      tag = "R1";
      pin_in = 1'b1;
      step(3);
      rst_n = 1'b1;
      pin_in = 1'b0;
      step(3);
      rd_addr = 1'b1; step();
      rd_addr = 1'b0; step();

      // R2: GPIO drive codes
      tag = "R2";
      wr(0, 32'h0000_0034); step(2);   // high
      wr(0, 32'h0000_0024); step(2);   // low
      wr(0, 32'h0000_0014); step(2);   // 01 input
      wr(0, 32'h0000_0004); step(2);   // 00 input

      // R3: open drain
      tag = "R3";
      wr(0, 32'h0000_0234); step(2);
      wr(0, 32'h0000_0224); step(2);

      // R4: compare/PWM follow the wave, off/capture release
      tag = "R4";
      wr(0, 32'h0000_0002);
      for (int i = 0; i < 6; i++) begin cnt_wave = i[0]; step(); end
      wr(0, 32'h0000_0203);
      for (int i = 0; i < 6; i++) begin cnt_wave = ~i[0]; step(); end
      wr(0, 32'h0000_0031); cnt_wave = 1'b1; step(2);
      wr(0, 32'h0000_0030); step(2);
      wr(0, 32'h0000_0037); step(2);
      cnt_wave = 1'b0;

      // R5: capture armed blocks GPIO drive
      tag = "R5";
      wr(0, 32'h0001_0034); step(2);
      wr(0, 32'h0003_0224); step(2);
      wr(0, 32'h0000_0034); step(2);

      // R6: level readback latency
      tag = "R6";
      rd_addr = 1'b1;
      wr(0, 32'h0000_0004);
      pin_set(1, 1); pin_set(0, 1); pin_set(1, 4); pin_set(0, 4);

      // R7: each edge selection
      tag = "R7";
      wr(0, 32'h0001_0101);          // rising, irq on
      pin_set(1, 5); wr(1, 32'h1); pin_set(0, 5);
      wr(0, 32'h0002_0101);          // falling
      pin_set(1, 5); pin_set(0, 5); wr(1, 32'hF);
      wr(0, 32'h0003_0101);          // either
      pin_set(1, 5); wr(1, 32'h1); pin_set(0, 5); wr(1, 32'h1);
      wr(0, 32'h0000_0101);          // none
      pin_set(1, 5); pin_set(0, 5);

      // R8: write-one-to-clear and set/clear collision
      tag = "R8";
      wr(0, 32'h0003_0001);
      pin_set(1, 5);
      wr(1, 32'h0);                  // zeros leave flag
      wr(1, 32'hE);                  // other bits do not touch bit 0
      wr(1, 32'h1); step(2);
      pin_in = 1'b0; step(2);        // edge reaches the flag on the next edge
      wr(1, 32'h1);                  // clear collides with new set
      step(2);
      wr(1, 32'h1); step(2);

      // R11 / R9: datapath events and interrupt gating
      tag = "R11";
      evt_set = 3'b101; step(); evt_set = '0; step(2);
      tag = "R9";
      wr(0, 32'h0000_0100); step(2);
      wr(0, 32'h0000_0000); step(2);
      wr(1, 32'h4); step(2);
      wr(0, 32'h0000_0100); step(2);
      wr(1, 32'hFFFF_FFFF); step(2);
      tag = "R11";
      evt_set = 3'b010; step(); evt_set = '0; step();

      // R10: register readback and reserved status bits
      tag = "R10";
      pin_set(1, 4);
      wr(1, 32'hFFFF_FEF0); step();
      rd_addr = 1'b0;
      wr(0, 32'hA5C3_0F00); step();
      wr(0, 32'h5A3C_F0FF); step();
      rd_addr = 1'b1; step();
      wr(1, 32'hFFFF_FFFF); step(2);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule